// File: doc/BRIEF.md
# Four-Channel Fly-By DMA Bus Master

This block moves data between memory and up to four peripherals without the processor touching each item. While the processor owns the bus, it uses a small register port to program each channel with a start address, an item count, a direction and a mode. Later it reads a status word that reports which channels have reached terminal count. A peripheral that wants service raises its request line. The engine picks a winner by fixed priority, asks the processor for the bus with `hold`, and waits for `holda`. It then drives the address, the winner's acknowledge and a read strobe followed by a write strobe. Each item therefore moves directly between memory and the peripheral in two bus cycles.

Every channel runs in one of three modes. In single mode the bus is released after each item. In block mode the engine keeps the bus until the count runs out. With auto-initialisation, the base address and count are reloaded at terminal count. A fourth, memory-to-memory operation is started by a software bit: channel 0 supplies the source address and the count, channel 1 supplies the destination, and a holding register carries the byte from the read cycle to the write cycle. To give the bus back, the engine turns its drivers off one cycle before it drops `hold`. It asks again only once `holda` has been seen low.

Top module: `dma_engine`

## Requirements
- R1: After reset `hold`, `bus_en`, every `dack` bit, all four strobes, `tc` and `data_oe` are low, and the status word reads 0.
- R2: Register select values are `4*c+0` for channel c's address, `4*c+1` for its count and `4*c+2` for its mode. The mode field has bit0 enable, bit1 direction (0 = memory to peripheral, 1 = peripheral to memory), bit2 block mode and bit3 auto-init. Writing the address or the count loads both the base copy and the current copy. A read returns the current address, the current count or the mode. Select `4*NUM_CH` is control (bit0 memory-to-memory, bit1 start) and select `4*NUM_CH+1` is status (bit c = channel c reached terminal count).
- R3: Among channels that are enabled and requesting, the lowest index wins. The request of a disabled channel is ignored, no new channel is taken while a transfer is in progress, and at most one `dack` bit is high.
- R4: `hold` rises in the cycle after a winning request is sampled while `holda` is low. The engine drives no bus signal before `holda` is sampled high.
- R5: In the cycle after `holda` is sampled high, `bus_en` is high, `bus_addr` carries the channel's current address and the channel's `dack` bit is high.
- R6: Each item takes one read cycle followed by one write cycle. Direction 0 gives `mem_rd` then `io_wr`; direction 1 gives `io_rd` then `mem_wr`.
- R7: To give the bus back, `bus_en` falls one cycle before `hold` falls. `hold` does not rise again until `holda` has been sampled low.
- R8: After each item the address increments by one and the 16-bit count decrements by one. An item that starts with a count of 0 is the last one: `tc` pulses for one cycle during its write cycle, and the channel's enable bit clears unless auto-init is set.
- R9: In single mode the engine releases the bus after every item. A request held high therefore gives one `hold` assertion per item.
- R10: In block mode the engine keeps the bus from the first item to terminal count, whatever the request line does.
- R11: With auto-init set, terminal count reloads the base address and count and the enable bit stays set.
- R12: With control bit0 set, the requests of channels 0 and 1 are masked. Setting the start bit moves count+1 bytes: each byte is read from channel 0's address with `mem_rd`, then written to channel 1's address with `mem_wr` and `data_oe`, and `dack` stays low. The start bit clears at terminal count.
- R13: Reading the status word clears the terminal-count flags. A flag that is set in the same cycle as the read survives it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_sel | input | CPU_AW | Register select |
| cpu_wr | input | 1 | Register write strobe |
| cpu_rd | input | 1 | Register read strobe (needed for the status clear) |
| cpu_wdata | input | REG_W | Register write data |
| cpu_rdata | output | REG_W | Register read data |
| drq | input | NUM_CH | Peripheral request lines |
| dack | output | NUM_CH | Peripheral acknowledge lines |
| hold | output | 1 | Bus request to the processor |
| holda | input | 1 | Bus grant from the processor |
| bus_en | output | 1 | Bus driver enable |
| bus_addr | output | ADDR_W | Memory address |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| io_rd | output | 1 | Peripheral read strobe |
| io_wr | output | 1 | Peripheral write strobe |
| tc | output | 1 | Terminal-count pulse |
| data_in | input | DATA_W | Memory read data (memory-to-memory only) |
| data_out | output | DATA_W | Memory write data (memory-to-memory only) |
| data_oe | output | 1 | Data driver enable |

## Verification
The bench builds the block with its defaults: four channels and 16-bit address, count and register width. The bench returns `holda` two cycles after `hold`, so the engine has to wait out a grant that arrives late and a grant that is still high after the bus has been given back. Counts are programmed as small values so that terminal count, the auto-init reload and the count wrapping to 0xFFFF all occur within a few dozen cycles. The memory in the bench returns a byte computed from the address, which lets every byte of the memory-to-memory copy be checked.

// File: rtl/dma_pkg.sv
package dma_pkg;

   typedef enum logic [2:0] {
      SQ_IDLE = 3'd0,
      SQ_HREQ = 3'd1,
      SQ_RD   = 3'd2,
      SQ_WR   = 3'd3,
      SQ_REL  = 3'd4
   } seq_state_t;

   typedef struct packed {
      logic autoinit;
      logic block;
      logic dir;
      logic en;
   } ch_mode_t;

   localparam int MODE_W     = 4;
   localparam int SLOT_ADDR  = 0;
   localparam int SLOT_CNT   = 1;
   localparam int SLOT_MODE  = 2;

endpackage

// File: rtl/dma_chan.sv
module dma_chan
   import dma_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int CNT_W  = 16,
   parameter int REG_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_addr,
   input  logic              wr_cnt,
   input  logic              wr_mode,
   input  logic [REG_W-1:0]  wdata,
   input  logic              step,
   input  logic              cnt_en,
   output logic [ADDR_W-1:0] cur_addr,
   output logic [CNT_W-1:0]  cur_cnt,
   output ch_mode_t          mode,
   output logic              at_tc
);

   logic [ADDR_W-1:0] base_addr;
   logic [CNT_W-1:0]  base_cnt;
   logic              reload;

   assign at_tc  = (cur_cnt == '0);
   assign reload = step && cnt_en && at_tc && mode.autoinit;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_addr <= '0;
         base_cnt  <= '0;
         cur_addr  <= '0;
         cur_cnt   <= '0;
         mode      <= '0;
      end else if (wr_addr || wr_cnt || wr_mode) begin
         if (wr_addr) begin
            base_addr <= wdata[ADDR_W-1:0];
            cur_addr  <= wdata[ADDR_W-1:0];
         end
         if (wr_cnt) begin
            base_cnt <= wdata[CNT_W-1:0];
            cur_cnt  <= wdata[CNT_W-1:0];
         end
         if (wr_mode) begin
            mode <= ch_mode_t'(wdata[MODE_W-1:0]);
         end
      end else if (step) begin
         if (reload) begin
            cur_addr <= base_addr;
            cur_cnt  <= base_cnt;
         end else begin
            cur_addr <= cur_addr + 1'b1;
            if (cnt_en) begin
               cur_cnt <= cur_cnt - 1'b1;
               if (at_tc) mode.en <= 1'b0;
            end
         end
      end
   end

   // R8
   cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step && cnt_en && !at_tc && !wr_addr && !wr_cnt && !wr_mode)
         |=> (cur_cnt == $past(cur_cnt) - 1'b1) && (cur_addr == $past(cur_addr) + 1'b1));

   // R8
   tc_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step && cnt_en && at_tc && !mode.autoinit && !wr_mode) |=> !mode.en);

   // R11
   reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reload && !wr_addr && !wr_cnt && !wr_mode)
         |=> (cur_addr == base_addr) && (cur_cnt == base_cnt) && mode.en == $past(mode.en));

endmodule

// File: rtl/dma_arb.sv
module dma_arb #(
   parameter int NUM_CH = 4,
   localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] req,
   output logic              gnt_vld,
   output logic [IDX_W-1:0]  gnt_idx
);

   always_comb begin
      gnt_vld = 1'b0;
      gnt_idx = '0;
      for (int i = NUM_CH - 1; i >= 0; i--) begin
         if (req[i]) begin
            gnt_vld = 1'b1;
            gnt_idx = IDX_W'(i);
         end
      end
   end

   logic [NUM_CH-1:0] below_mask;
   assign below_mask = (NUM_CH'(1) << gnt_idx) - NUM_CH'(1);

   // R3
   low_index_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|req) |-> (gnt_vld && req[gnt_idx] && ((req & below_mask) == '0)));

   // R3
   no_req_no_gnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req == '0) |-> !gnt_vld);

endmodule

// File: rtl/dma_seq.sv
module dma_seq
   import dma_pkg::*;
#(
   parameter int IDX_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             go_m2m,
   input  logic             gnt_vld,
   input  logic [IDX_W-1:0] gnt_idx,
   input  logic             holda,
   input  logic             last,
   input  logic             blk,
   output seq_state_t       state,
   output logic [IDX_W-1:0] srv_ch,
   output logic             srv_m2m
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= SQ_IDLE;
         srv_ch  <= '0;
         srv_m2m <= 1'b0;
      end else begin
         unique case (state)
            SQ_IDLE: begin
               if (!holda) begin
                  if (go_m2m) begin
                     srv_m2m <= 1'b1;
                     srv_ch  <= '0;
                     state   <= SQ_HREQ;
                  end else if (gnt_vld) begin
                     srv_m2m <= 1'b0;
                     srv_ch  <= gnt_idx;
                     state   <= SQ_HREQ;
                  end
               end
            end
            SQ_HREQ: if (holda) state <= SQ_RD;
            SQ_RD:   state <= SQ_WR;
            SQ_WR: begin
               if (last || (!blk && !srv_m2m)) state <= SQ_REL;
               else                            state <= SQ_RD;
            end
            SQ_REL:  state <= SQ_IDLE;
            default: state <= SQ_IDLE;
         endcase
      end
   end

   // R7
   rel_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == SQ_REL) |=> (state == SQ_IDLE));

   // R4
   wait_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == SQ_HREQ && !holda) |=> (state == SQ_HREQ));

   // R10
   block_keeps_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == SQ_WR && blk && !last) |=> (state == SQ_RD));

endmodule

// File: rtl/dma_engine.sv
module dma_engine
   import dma_pkg::*;
#(
   parameter int NUM_CH = 4,
   parameter int ADDR_W = 16,
   parameter int CNT_W  = 16,
   parameter int REG_W  = 16,
   parameter int DATA_W = 8,
   localparam int CPU_AW = $clog2(NUM_CH * 4 + 2)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CPU_AW-1:0] cpu_sel,
   input  logic              cpu_wr,
   input  logic              cpu_rd,
   input  logic [REG_W-1:0]  cpu_wdata,
   output logic [REG_W-1:0]  cpu_rdata,
   input  logic [NUM_CH-1:0] drq,
   output logic [NUM_CH-1:0] dack,
   output logic              hold,
   input  logic              holda,
   output logic              bus_en,
   output logic [ADDR_W-1:0] bus_addr,
   output logic              mem_rd,
   output logic              mem_wr,
   output logic              io_rd,
   output logic              io_wr,
   output logic              tc,
   input  logic [DATA_W-1:0] data_in,
   output logic [DATA_W-1:0] data_out,
   output logic              data_oe
);

   localparam int IDX_W    = $clog2(NUM_CH);
   localparam int CTRL_SEL = NUM_CH * 4;
   localparam int STAT_SEL = NUM_CH * 4 + 1;

   // elaboration-time parameter checks
   if (NUM_CH < 2 || (NUM_CH & (NUM_CH - 1)) != 0) begin : g_bad_nch
      $error("NUM_CH must be a power of two and at least 2");
   end
   if (ADDR_W > REG_W || CNT_W > REG_W) begin : g_bad_width
      $error("ADDR_W and CNT_W must fit in REG_W");
   end
   if (REG_W < NUM_CH || REG_W < MODE_W) begin : g_bad_reg
      $error("REG_W too narrow for status or mode");
   end

   // register decode
   logic             is_chan;
   logic [IDX_W-1:0] sel_ch;
   logic [1:0]       sel_slot;

   assign is_chan  = (cpu_sel < CPU_AW'(CTRL_SEL));
   assign sel_ch   = cpu_sel[2 +: IDX_W];
   assign sel_slot = cpu_sel[1:0];

   // channel state
   logic [ADDR_W-1:0] ch_addr [NUM_CH];
   logic [CNT_W-1:0]  ch_cnt  [NUM_CH];
   ch_mode_t          ch_mode [NUM_CH];
   logic [NUM_CH-1:0] ch_tc;
   logic [NUM_CH-1:0] ch_en;
   logic [NUM_CH-1:0] req;

   // control and status
   logic              ctl_m2m;
   logic              ctl_start;
   logic [NUM_CH-1:0] tc_flags;

   // sequencer
   seq_state_t       st;
   logic [IDX_W-1:0] srv_ch;
   logic             srv_m2m;
   logic             gnt_vld;
   logic [IDX_W-1:0] gnt_idx;
   logic             seq_step;
   logic             last;
   logic [DATA_W-1:0] data_hold;

   assign seq_step = (st == SQ_WR);
   assign last     = ch_tc[srv_ch];

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      logic wr_a, wr_c, wr_m, step_c, cnt_en_c;

      assign wr_a = cpu_wr && is_chan && (sel_ch == IDX_W'(c)) && (sel_slot == 2'(SLOT_ADDR));
      assign wr_c = cpu_wr && is_chan && (sel_ch == IDX_W'(c)) && (sel_slot == 2'(SLOT_CNT));
      assign wr_m = cpu_wr && is_chan && (sel_ch == IDX_W'(c)) && (sel_slot == 2'(SLOT_MODE));

      if (c == 1) begin : g_dst
         assign step_c   = seq_step && (srv_m2m || srv_ch == IDX_W'(c));
         assign cnt_en_c = !srv_m2m;
      end else begin : g_src
         assign step_c   = seq_step && (srv_ch == IDX_W'(c));
         assign cnt_en_c = 1'b1;
      end

      if (c < 2) begin : g_mask
         assign req[c] = ch_mode[c].en && drq[c] && !ctl_m2m;
      end else begin : g_nomask
         assign req[c] = ch_mode[c].en && drq[c];
      end

      assign ch_en[c] = ch_mode[c].en;

      dma_chan #(
         .ADDR_W (ADDR_W),
         .CNT_W  (CNT_W),
         .REG_W  (REG_W)
      ) u_chan (
         .clk      (clk),
         .rst_n    (rst_n),
         .wr_addr  (wr_a),
         .wr_cnt   (wr_c),
         .wr_mode  (wr_m),
         .wdata    (cpu_wdata),
         .step     (step_c),
         .cnt_en   (cnt_en_c),
         .cur_addr (ch_addr[c]),
         .cur_cnt  (ch_cnt[c]),
         .mode     (ch_mode[c]),
         .at_tc    (ch_tc[c])
      );
   end

   dma_arb #(
      .NUM_CH (NUM_CH)
   ) u_arb (
      .clk     (clk),
      .rst_n   (rst_n),
      .req     (req),
      .gnt_vld (gnt_vld),
      .gnt_idx (gnt_idx)
   );

   dma_seq #(
      .IDX_W (IDX_W)
   ) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .go_m2m  (ctl_m2m && ctl_start),
      .gnt_vld (gnt_vld),
      .gnt_idx (gnt_idx),
      .holda   (holda),
      .last    (last),
      .blk     (ch_mode[srv_ch].block),
      .state   (st),
      .srv_ch  (srv_ch),
      .srv_m2m (srv_m2m)
   );

   // control register, status flags, holding register
   logic [NUM_CH-1:0] tc_set;
   logic              stat_rd;

   assign tc_set  = tc ? (NUM_CH'(1) << srv_ch) : '0;
   assign stat_rd = cpu_rd && (cpu_sel == CPU_AW'(STAT_SEL));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctl_m2m   <= 1'b0;
         ctl_start <= 1'b0;
         tc_flags  <= '0;
         data_hold <= '0;
      end else begin
         if (cpu_wr && cpu_sel == CPU_AW'(CTRL_SEL)) begin
            ctl_m2m   <= cpu_wdata[0];
            ctl_start <= cpu_wdata[1];
         end else if (seq_step && srv_m2m && last) begin
            ctl_start <= 1'b0;
         end
         tc_flags <= stat_rd ? tc_set : (tc_flags | tc_set);
         if (st == SQ_RD && srv_m2m) data_hold <= data_in;
      end
   end

   // bus outputs
   logic rd_ph, wr_ph, dir_in;

   assign rd_ph  = (st == SQ_RD);
   assign wr_ph  = (st == SQ_WR);
   assign dir_in = ch_mode[srv_ch].dir;

   assign hold     = (st != SQ_IDLE);
   assign bus_en   = rd_ph || wr_ph;
   assign bus_addr = !bus_en            ? '0 :
                     (wr_ph && srv_m2m) ? ch_addr[1] : ch_addr[srv_ch];
   assign dack     = (bus_en && !srv_m2m) ? (NUM_CH'(1) << srv_ch) : '0;
   assign mem_rd   = rd_ph && (srv_m2m || !dir_in);
   assign io_rd    = rd_ph && !srv_m2m && dir_in;
   assign io_wr    = wr_ph && !srv_m2m && !dir_in;
   assign mem_wr   = wr_ph && (srv_m2m || dir_in);
   assign tc       = wr_ph && last;
   assign data_oe  = wr_ph && srv_m2m;
   assign data_out = data_oe ? data_hold : '0;

   // register read
   always_comb begin
      cpu_rdata = '0;
      if (is_chan) begin
         unique case (sel_slot)
            2'(SLOT_ADDR): cpu_rdata = REG_W'(ch_addr[sel_ch]);
            2'(SLOT_CNT):  cpu_rdata = REG_W'(ch_cnt[sel_ch]);
            2'(SLOT_MODE): cpu_rdata = REG_W'(ch_mode[sel_ch]);
            default:       cpu_rdata = '0;
         endcase
      end else if (cpu_sel == CPU_AW'(CTRL_SEL)) begin
         cpu_rdata = REG_W'({ctl_start, ctl_m2m});
      end else if (cpu_sel == CPU_AW'(STAT_SEL)) begin
         cpu_rdata = REG_W'(tc_flags);
      end
   end

   // R4
   hold_needs_low_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hold) |-> $past(!holda));

   // R5
   drive_after_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_en) |-> ($past(holda) && $past(hold)));

   // R7
   drivers_off_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(hold) |-> $past(!bus_en));

   // R3
   one_dack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(dack));

   // R3
   dack_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|dack) |-> (|(dack & ch_en)));

   // R6
   one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({mem_rd, mem_wr, io_rd, io_wr}) <= 1);

   // R6
   write_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_wr || io_wr) |-> $past(mem_rd || io_rd));

   // R8
   tc_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tc |=> !tc);

   // R12
   copy_no_dack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      data_oe |-> (mem_wr && dack == '0));

   // R13
   stat_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_rd && !tc) |=> (tc_flags == '0));

endmodule

// File: tb/dma_engine_tb.sv
module dma_engine_tb;

   localparam int CLK_PERIOD = 10;
   localparam int NUM_CH     = 4;
   localparam int ADDR_W     = 16;
   localparam int CNT_W      = 16;
   localparam int REG_W      = 16;
   localparam int DATA_W     = 8;
   localparam int CPU_AW     = 5;
   localparam int CTRL_SEL   = 16;
   localparam int STAT_SEL   = 17;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [CPU_AW-1:0] cpu_sel = '0;
   logic              cpu_wr = 1'b0;
   logic              cpu_rd = 1'b0;
   logic [REG_W-1:0]  cpu_wdata = '0;
   logic [REG_W-1:0]  cpu_rdata;
   logic [NUM_CH-1:0] drq = '0;
   logic [NUM_CH-1:0] dack;
   logic              hold;
   logic              holda = 1'b0;
   logic              holda_p = 1'b0;
   logic              bus_en;
   logic [ADDR_W-1:0] bus_addr;
   logic              mem_rd, mem_wr, io_rd, io_wr, tc;
   logic [DATA_W-1:0] data_in;
   logic [DATA_W-1:0] data_out;
   logic              data_oe;

   int n_chk = 0;
   int n_err = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   dma_engine #(
      .NUM_CH (NUM_CH), .ADDR_W (ADDR_W), .CNT_W (CNT_W),
      .REG_W (REG_W), .DATA_W (DATA_W)
   ) u_dut (
      .clk (clk), .rst_n (rst_n), .cpu_sel (cpu_sel), .cpu_wr (cpu_wr),
      .cpu_rd (cpu_rd), .cpu_wdata (cpu_wdata), .cpu_rdata (cpu_rdata),
      .drq (drq), .dack (dack), .hold (hold), .holda (holda),
      .bus_en (bus_en), .bus_addr (bus_addr), .mem_rd (mem_rd),
      .mem_wr (mem_wr), .io_rd (io_rd), .io_wr (io_wr), .tc (tc),
      .data_in (data_in), .data_out (data_out), .data_oe (data_oe)
   );

   // bench memory: byte derived from the address
   assign data_in = bus_addr[7:0] ^ 8'h5A;

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // processor model: grant follows request two cycles later
   always @(negedge clk) begin
      holda   <= holda_p;
      holda_p <= hold;
   end

   // ---------------- behavioural reference model ----------------
   int m_st;
   int m_ch;
   bit m_mm;
   int m_a[4], m_c[4], m_ba[4], m_bc[4];
   bit m_en[4], m_dir[4], m_blk[4], m_ai[4];
   bit m_mmode, m_start;
   int m_flags;
   int m_hd;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_st = 0; m_ch = 0; m_mm = 0; m_mmode = 0; m_start = 0;
         m_flags = 0; m_hd = 0;
         for (int i = 0; i < 4; i++) begin
            m_a[i] = 0; m_c[i] = 0; m_ba[i] = 0; m_bc[i] = 0;
            m_en[i] = 0; m_dir[i] = 0; m_blk[i] = 0; m_ai[i] = 0;
         end
      end else begin
         int nst;
         int setb;
         bit found;
         nst = m_st;
         setb = 0;
         found = 0;
         case (m_st)
            0: if (!holda) begin
               if (m_mmode && m_start) begin
                  m_mm = 1; m_ch = 0; nst = 1;
               end else begin
                  for (int i = 0; i < 4; i++) begin
                     if (!found && m_en[i] && drq[i] && !(m_mmode && i < 2)) begin
                        found = 1; m_mm = 0; m_ch = i; nst = 1;
                     end
                  end
               end
            end
            1: if (holda) nst = 2;
            2: begin
               if (m_mm) m_hd = (m_a[0] & 255) ^ 'h5A;
               nst = 3;
            end
            3: begin
               bit lst;
               int c;
               c = m_ch;
               lst = (m_c[c] == 0);
               if (lst && m_ai[c]) begin
                  m_a[c] = m_ba[c]; m_c[c] = m_bc[c];
               end else begin
                  m_a[c] = (m_a[c] + 1) & 'hFFFF;
                  m_c[c] = (m_c[c] - 1) & 'hFFFF;
                  if (lst) m_en[c] = 0;
               end
               if (m_mm) m_a[1] = (m_a[1] + 1) & 'hFFFF;
               if (lst) begin
                  setb = 1 << c;
                  if (m_mm) m_start = 0;
               end
               nst = (lst || (!m_blk[c] && !m_mm)) ? 4 : 2;
            end
            default: nst = 0;
         endcase
         m_st = nst;
         if (cpu_wr) begin
            if (cpu_sel < CTRL_SEL) begin
               int c, s;
               c = cpu_sel / 4;
               s = cpu_sel % 4;
               if (s == 0) begin m_ba[c] = cpu_wdata; m_a[c] = cpu_wdata; end
               if (s == 1) begin m_bc[c] = cpu_wdata; m_c[c] = cpu_wdata; end
               if (s == 2) begin
                  m_en[c] = cpu_wdata[0]; m_dir[c] = cpu_wdata[1];
                  m_blk[c] = cpu_wdata[2]; m_ai[c] = cpu_wdata[3];
               end
            end else if (cpu_sel == CTRL_SEL) begin
               m_mmode = cpu_wdata[0]; m_start = cpu_wdata[1];
            end
         end
         m_flags = (cpu_rd && cpu_sel == STAT_SEL) ? setb : (m_flags | setb);
      end
   end

   // per-cycle comparison of every bus output against the model
   always @(negedge clk) begin
      if (rst_n) begin
         bit e_be;
         int e_addr, e_dack;
         bit e_mrd, e_mwr, e_ird, e_iwr, e_tc, e_oe;
         int e_do;
         e_be   = (m_st == 2 || m_st == 3);
         e_addr = !e_be ? 0 : ((m_st == 3 && m_mm) ? m_a[1] : m_a[m_ch]);
         e_dack = (e_be && !m_mm) ? (1 << m_ch) : 0;
         e_mrd  = (m_st == 2) && (m_mm || !m_dir[m_ch]);
         e_ird  = (m_st == 2) && !m_mm && m_dir[m_ch];
         e_iwr  = (m_st == 3) && !m_mm && !m_dir[m_ch];
         e_mwr  = (m_st == 3) && (m_mm || m_dir[m_ch]);
         e_tc   = (m_st == 3) && (m_c[m_ch] == 0);
         e_oe   = (m_st == 3) && m_mm;
         e_do   = e_oe ? m_hd : 0;
         chk(hold == (m_st != 0), "R4/R7 hold", hold, m_st != 0);
         chk(bus_en == e_be, "R5/R7 bus_en", bus_en, e_be);
         chk(bus_addr == e_addr, "R5 bus_addr", bus_addr, e_addr);
         chk(dack == e_dack, "R3/R5 dack", dack, e_dack);
         chk({mem_rd, io_rd, io_wr, mem_wr} == {e_mrd, e_ird, e_iwr, e_mwr},
             "R6 strobes", {mem_rd, io_rd, io_wr, mem_wr}, {e_mrd, e_ird, e_iwr, e_mwr});
         chk(tc == e_tc, "R8 tc", tc, e_tc);
         chk({data_oe, data_out} == {e_oe, 8'(e_do)}, "R12 data", {data_oe, data_out}, {e_oe, 8'(e_do)});
      end
   end

   // bench-side observers
   int hold_rises = 0;
   int tc_seen = 0;
   int first_dack = 0;
   bit dack0_seen = 0;
   bit prev_hold = 0;
   logic [7:0] wmem [256];

   always @(negedge clk) begin
      if (hold && !prev_hold) hold_rises++;
      prev_hold = hold;
      if (tc) tc_seen++;
      if (first_dack == 0 && dack != 0) first_dack = dack;
      if (dack[0]) dack0_seen = 1;
      if (data_oe && mem_wr) wmem[bus_addr[7:0]] = data_out;
   end

   task automatic wr_reg(input int sel, input int val);
      @(negedge clk);
      cpu_sel = CPU_AW'(sel); cpu_wdata = REG_W'(val); cpu_wr = 1'b1;
      @(negedge clk);
      cpu_wr = 1'b0;
   endtask

   task automatic rd_reg(input int sel, input int exp, input string tag);
      @(negedge clk);
      cpu_sel = CPU_AW'(sel); cpu_rd = 1'b1;
      #1;
      chk(cpu_rdata == REG_W'(exp), tag, cpu_rdata, exp);
      @(negedge clk);
      cpu_rd = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_err++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      idle(4);
      rst_n = 1'b1;
      #1;
      // R1 reset state
      chk({hold, bus_en, dack, mem_rd, mem_wr, io_rd, io_wr, tc, data_oe} == '0,
          "R1 outputs", {hold, bus_en, dack}, 0);
      rd_reg(STAT_SEL, 0, "R1 status");

      // R2 programming and read-back, channel 2: single, memory to peripheral
      wr_reg(8, 'h0100);
      wr_reg(9, 2);
      wr_reg(10, 'h1);
      rd_reg(8, 'h0100, "R2 addr");
      rd_reg(9, 2, "R2 count");
      rd_reg(10, 'h1, "R2 mode");

      // R9 single mode: three items, one hold per item
      hold_rises = 0;
      drq[2] = 1'b1;
      idle(60);
      drq[2] = 1'b0;
      idle(6);
      chk(hold_rises == 3, "R9 hold per item", hold_rises, 3);
      rd_reg(8, 'h0103, "R8 addr advanced");
      rd_reg(9, 'hFFFF, "R8 count wrapped");
      rd_reg(10, 'h0, "R8 enable cleared");
      rd_reg(STAT_SEL, 'h4, "R13 flag set");
      rd_reg(STAT_SEL, 'h0, "R13 flag cleared");

      // R3 priority and R10 block: ch1 and ch3 in block mode, ch0 disabled
      wr_reg(4, 'h0200); wr_reg(5, 3); wr_reg(6, 'h5);
      wr_reg(12, 'h0300); wr_reg(13, 1); wr_reg(14, 'h7);
      hold_rises = 0; first_dack = 0; dack0_seen = 0;
      drq = 4'b1011;
      idle(80);
      drq = '0;
      idle(6);
      chk(first_dack == 2, "R3 lowest enabled wins", first_dack, 2);
      chk(!dack0_seen, "R3 disabled ignored", dack0_seen, 0);
      chk(hold_rises == 2, "R10 one hold per block", hold_rises, 2);
      rd_reg(4, 'h0204, "R10 ch1 addr");
      rd_reg(12, 'h0302, "R10 ch3 addr");
      rd_reg(STAT_SEL, 'hA, "R13 two flags");

      // R11 auto-init on ch3: block, peripheral to memory
      wr_reg(12, 'h0040); wr_reg(13, 1); wr_reg(14, 'hF);
      tc_seen = 0;
      drq[3] = 1'b1;
      for (int k = 0; k < 200 && tc_seen < 3; k++) @(negedge clk);
      drq[3] = 1'b0;
      chk(tc_seen == 3, "R11 repeated bursts", tc_seen, 3);
      idle(8);
      rd_reg(12, 'h0040, "R11 addr reloaded");
      rd_reg(13, 1, "R11 count reloaded");
      rd_reg(14, 'hF, "R11 enable kept");
      rd_reg(STAT_SEL, 'h8, "R13 ch3 flag");

      // R12 memory to memory: 0x20..0x23 -> 0x80..0x83
      wr_reg(0, 'h0020); wr_reg(1, 3); wr_reg(4, 'h0080);
      drq[1] = 1'b1;
      wr_reg(CTRL_SEL, 3);
      for (int k = 0; k < 200; k++) begin
         @(negedge clk);
         if (!hold && m_start == 0) break;
      end
      idle(6);
      drq[1] = 1'b0;
      rd_reg(CTRL_SEL, 1, "R12 start cleared");
      rd_reg(4, 'h0084, "R12 dest addr");
      rd_reg(0, 'h0024, "R12 src addr");
      rd_reg(STAT_SEL, 'h1, "R12 ch0 flag");
      for (int k = 0; k < 4; k++) begin
         chk(wmem[8'h80 + k] == ((8'h20 + 8'(k)) ^ 8'h5A), "R12 copied byte",
             wmem[8'h80 + k], (8'h20 + 8'(k)) ^ 8'h5A);
      end
      wr_reg(CTRL_SEL, 0);
      idle(4);

      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

endmodule